// File: doc/BRIEF.md
# Gated Interval Timers with Trigger-Go Watchdog

This block keeps two free-running 16-bit interval timers and a trigger-go watchdog counter. All three advance once for each rising edge of a slow external timer clock. That clock is brought into the system clock domain through a two-flop synchronizer followed by an edge detector. A software GO strobe restarts the watchdog counter. When the watchdog counter wraps from all ones to zero, an active-low overflow flag drops and stays low until the next GO.

An active-low freeze input stops all three counters; they keep their values and continue from them when the input returns high. While the block is frozen, and while it is held in reset, the DMA handshake outputs are forced to their idle levels (enable low, active-low acknowledge high). Otherwise they follow the request-side inputs. A separate bus-fault timeout counts system clocks while a bus cycle is active and ready is absent. It produces a single-cycle fault pulse once a stall reaches a parameter limit. An active-low guard input holds this timeout in reset.

The counter values are driven out as ports so that the surrounding logic can observe them.

Top module: `gated_timer_unit`

## Requirements
- R1: While `rst_n` is low, `timer_a`, `timer_b` and `tg_count` are zero, `tg_ovf_n` is high, `bus_fault` is low, `dma_en` is low and `dma_ack_n` is high. After reset the counters start from zero.
- R2: Each rising edge of `tick_in` advances `timer_a`, `timer_b` and `tg_count` by exactly one, provided `freeze_n` is high. The new value appears on the third rising system-clock edge after `tick_in` rises. A level held high produces no further advance.
- R3: While `freeze_n` is low, tick edges do not advance any of the three counters. When `freeze_n` returns high, counting resumes from the values held, without a reload.
- R4: While `freeze_n` is low, `dma_en` is 0 and `dma_ack_n` is 1. While it is high (and out of reset), `dma_en` equals `dma_en_req` and `dma_ack_n` equals `dma_ack_n_req`.
- R5: When `tg_count` advances from all ones to zero, `tg_ovf_n` goes low in the same cycle. It stays low through later advances.
- R6: A one-cycle high on `go` clears `tg_count` to zero and sets `tg_ovf_n` high on the next clock edge. It leaves `timer_a` and `timer_b` unchanged.
- R7: When `go` falls in the same cycle as a wrap of `tg_count`, the result is `tg_count` = 0 with `tg_ovf_n` still high.
- R8: When `bus_busy` is high and `bus_ready` is low for FAULT_LIMIT consecutive clock edges, `bus_fault` pulses high for exactly one cycle. It does not pulse again while the same stall lasts.
- R9: A cycle with `bus_ready` high or `bus_busy` low restarts the stall count from zero.
- R10: While `fault_guard_n` is low, the stall count is held at zero and `bus_fault` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | External timer clock, asynchronous to clk |
| freeze_n | input | 1 | Active-low counter freeze and DMA block |
| fault_guard_n | input | 1 | Active-low bus-fault timeout reset/disable |
| go | input | 1 | GO command strobe, one cycle |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_ready | input | 1 | Bus ready seen this cycle |
| dma_en_req | input | 1 | DMA enable from the handshake logic |
| dma_ack_n_req | input | 1 | Active-low DMA acknowledge from the handshake logic |
| timer_a | output | CNT_W | Interval timer A value |
| timer_b | output | CNT_W | Interval timer B value |
| tg_count | output | CNT_W | Trigger-go counter value |
| tg_ovf_n | output | 1 | Active-low trigger-go overflow flag |
| dma_en | output | 1 | Gated DMA enable |
| dma_ack_n | output | 1 | Gated active-low DMA acknowledge |
| bus_fault | output | 1 | One-cycle bus-fault timeout pulse |

## Verification
The counters are driven by bursts of tick edges with the freeze input alternately high and low. This separates an advance that is correctly gated from one that leaks through or one that reloads on resume. The DMA outputs are checked against the requests in both freeze states. Tick timing is probed one cycle before and on the expected update edge, and a long-held tick level shows that only edges count. The watchdog is walked across its wrap, past it, through a GO, and through a GO timed onto the wrapping edge. The stall counter is tried with an unbroken stall, a stall broken by a ready cycle, and a stall with the guard low, which tell the pulse, its restart and its suppression apart.

// File: rtl/gated_timer_unit.sv
module gated_timer_unit #(
  parameter int CNT_W       = 16,
  parameter int FAULT_LIMIT = 256,
  localparam int FW         = $clog2(FAULT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             freeze_n,
  input  logic             fault_guard_n,
  input  logic             go,
  input  logic             bus_busy,
  input  logic             bus_ready,
  input  logic             dma_en_req,
  input  logic             dma_ack_n_req,
  output logic [CNT_W-1:0] timer_a,
  output logic [CNT_W-1:0] timer_b,
  output logic [CNT_W-1:0] tg_count,
  output logic             tg_ovf_n,
  output logic             dma_en,
  output logic             dma_ack_n,
  output logic             bus_fault
);

  logic [2:0]    tick_sync;
  logic          tick_rise, advance, dma_ok;
  logic [FW-1:0] stall_cnt;
  logic          stall_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_sync <= '0;
    else        tick_sync <= {tick_sync[1:0], tick_in};
  end

  assign tick_rise = tick_sync[1] & ~tick_sync[2];
  assign advance   = tick_rise & freeze_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_a <= '0;
      timer_b <= '0;
    end else if (advance) begin
      timer_a <= timer_a + CNT_W'(1);
      timer_b <= timer_b + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tg_count <= '0;
      tg_ovf_n <= 1'b1;
    end else if (go) begin
      tg_count <= '0;
      tg_ovf_n <= 1'b1;
    end else if (advance) begin
      tg_count <= tg_count + CNT_W'(1);
      if (&tg_count) tg_ovf_n <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dma_ok <= 1'b0;
    else        dma_ok <= 1'b1;
  end

  assign dma_en    = dma_ok & freeze_n & dma_en_req;
  assign dma_ack_n = ~(dma_ok & freeze_n) | dma_ack_n_req;

  assign stall_clear = ~fault_guard_n | ~bus_busy | bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || stall_clear) begin
      stall_cnt <= '0;
      bus_fault <= 1'b0;
    end else begin
      bus_fault <= (stall_cnt == FW'(FAULT_LIMIT - 1));
      if (stall_cnt != FW'(FAULT_LIMIT)) stall_cnt <= stall_cnt + FW'(1);
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (timer_a == '0 && tg_count == '0 && tg_ovf_n && !bus_fault));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_a != $past(timer_a)) |-> (timer_a == $past(timer_a) + CNT_W'(1)));

  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_n |=> (timer_a == $past(timer_a) && timer_b == $past(timer_b)));

  assert_dma_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_n |-> (!dma_en && dma_ack_n));

  assert_go_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (tg_count == '0 && tg_ovf_n));

  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> !bus_fault);

  assert_guard_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_guard_n |=> !bus_fault);

endmodule

// File: tb/gated_timer_unit_bench.sv
module gated_timer_unit_bench;
  localparam int W = 8;
  localparam int LIM = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0, freeze_n = 1'b1, fault_guard_n = 1'b1;
  logic go = 1'b0, bus_busy = 1'b0, bus_ready = 1'b0, dma_en_req = 1'b1, dma_ack_n_req = 1'b0;
  logic [W-1:0] timer_a, timer_b, tg_count;
  logic tg_ovf_n, dma_en, dma_ack_n, bus_fault;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gated_timer_unit #(.CNT_W(W), .FAULT_LIMIT(LIM)) u_gated_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .freeze_n(freeze_n),
    .fault_guard_n(fault_guard_n), .go(go), .bus_busy(bus_busy), .bus_ready(bus_ready),
    .dma_en_req(dma_en_req), .dma_ack_n_req(dma_ack_n_req),
    .timer_a(timer_a), .timer_b(timer_b), .tg_count(tg_count), .tg_ovf_n(tg_ovf_n),
    .dma_en(dma_en), .dma_ack_n(dma_ack_n), .bus_fault(bus_fault));

  // row: {ticks[12:9], freeze_n[8], expected timer value[7:0]}
  localparam logic [12:0] VEC [5] = '{
    {4'd3, 1'b1, 8'd3}, {4'd2, 1'b0, 8'd3}, {4'd4, 1'b1, 8'd7},
    {4'd1, 1'b0, 8'd7}, {4'd5, 1'b1, 8'd12}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick_in = 1'b1; nclk(4);
    tick_in = 1'b0; nclk(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    nclk(3);
    check(timer_a == 0 && timer_b == 0 && tg_count == 0, "R1 counters in reset", timer_a, 0);
    check(tg_ovf_n && !bus_fault, "R1 flags in reset", {tg_ovf_n, bus_fault}, 2);
    check(!dma_en && dma_ack_n, "R1 dma idle in reset", {dma_en, dma_ack_n}, 1);
    rst_n = 1'b1; nclk(2);

    foreach (VEC[i]) begin
      freeze_n = VEC[i][8]; nclk(1);
      if (VEC[i][8]) check(dma_en && !dma_ack_n, "R4 dma passes", {dma_en, dma_ack_n}, 2);
      else           check(!dma_en && dma_ack_n, "R4 dma blocked", {dma_en, dma_ack_n}, 1);
      for (int t = 0; t < int'(VEC[i][12:9]); t++) pulse_tick();
      check(timer_a == VEC[i][7:0], "R3 timer_a table", timer_a, VEC[i][7:0]);
      check(timer_b == VEC[i][7:0] && tg_count == VEC[i][7:0], "R2 timer_b/tg table", timer_b, VEC[i][7:0]);
    end
    freeze_n = 1'b1; nclk(1);

    // R2 latency: rises at n0, unchanged at n2, updated at n3; held level gives one step
    tick_in = 1'b1; nclk(2);
    check(timer_a == 12, "R2 before update edge", timer_a, 12);
    nclk(1);
    check(timer_a == 13, "R2 on update edge", timer_a, 13);
    nclk(10);
    check(timer_a == 13, "R2 held level no extra step", timer_a, 13);
    tick_in = 1'b0; nclk(4);

    // R6 GO clears tg only
    go = 1'b1; nclk(1); go = 1'b0;
    check(tg_count == 0 && tg_ovf_n, "R6 go clears tg", tg_count, 0);
    check(timer_a == 13 && timer_b == 13, "R6 timers untouched", timer_a, 13);

    // R5 wrap
    for (int t = 0; t < 256; t++) pulse_tick();
    check(tg_count == 0 && !tg_ovf_n, "R5 wrap drops flag", {tg_count, tg_ovf_n}, 0);
    pulse_tick();
    check(tg_count == 1 && !tg_ovf_n, "R5 flag stays low", {tg_count, tg_ovf_n}, 2);
    go = 1'b1; nclk(1); go = 1'b0;
    check(tg_ovf_n && tg_count == 0, "R6 go restores flag", tg_ovf_n, 1);

    // R7 GO on the wrapping edge
    for (int t = 0; t < 255; t++) pulse_tick();
    check(tg_count == 255, "R7 setup at all ones", tg_count, 255);
    tick_in = 1'b1; nclk(2);
    go = 1'b1; nclk(1); go = 1'b0;
    check(tg_count == 0 && tg_ovf_n, "R7 go wins over wrap", {tg_count, tg_ovf_n}, 1);
    tick_in = 1'b0; nclk(4);

    // R8 unbroken stall
    bus_busy = 1'b1; nclk(15);
    check(!bus_fault, "R8 no fault before limit", bus_fault, 0);
    nclk(1);
    check(bus_fault, "R8 fault at limit", bus_fault, 1);
    nclk(1);
    check(!bus_fault, "R8 one-cycle pulse", bus_fault, 0);
    begin
      bit seen = 0;
      for (int k = 0; k < 30; k++) begin nclk(1); seen |= bus_fault; end
      check(!seen, "R8 no repeat in same stall", seen, 0);
    end
    bus_busy = 1'b0; nclk(2);

    // R9 ready restarts count
    bus_busy = 1'b1; nclk(10);
    bus_ready = 1'b1; nclk(1); bus_ready = 1'b0;
    begin
      bit seen = 0;
      for (int k = 0; k < 15; k++) begin nclk(1); seen |= bus_fault; end
      check(!seen, "R9 ready restarted count", seen, 0);
    end
    nclk(1);
    check(bus_fault, "R9 fault after full new stall", bus_fault, 1);
    bus_busy = 1'b0; nclk(2);

    // R10 guard low
    fault_guard_n = 1'b0; bus_busy = 1'b1;
    begin
      bit seen = 0;
      for (int k = 0; k < 40; k++) begin nclk(1); seen |= bus_fault; end
      check(!seen, "R10 guard suppresses fault", seen, 0);
    end
    fault_guard_n = 1'b1; nclk(16);
    check(bus_fault, "R10 count started from zero after guard", bus_fault, 1);
    bus_busy = 1'b0; nclk(2);

    finish_run();
  end
endmodule